// File: doc/BRIEF.md
# Pixel Bus Flag Control: Shift-Clock Stretch and Nibble Pick

This block sits between a pixel data bus and the pixel latch of a video palette. It serves one flag input whose meaning depends on a two-bit mode field taken from a general control register. In split-transfer mode, a rising flag seen while the display is blanked adds one extra shift-clock pulse. The memory uses that pulse to reload the half of its serial register that is idle. In nibble mode, the flag is sampled when the video clock falls. The sampled value decides whether the upper or the lower four bits of every byte on the pixel bus are latched at the next rising edge of the base shift clock. In the remaining legal mode the flag is ignored. The fourth encoding is illegal: an indicator is raised, and the block then acts as in the ignore mode.

All inputs are captured on the rising edge of one fast system clock `clk`. The video clock and the base shift clock are handled as sampled levels, and their edges are found by comparing each captured value with the one captured before it. Every output is driven straight from a register.

Top module: `pixbus_flag_ctrl`

## Requirements
- R1: `mode` is decoded as follows: 2'b00 = flag ignored, 2'b01 = split transfer, 2'b10 = nibble pick, 2'b11 = illegal. `illegal_mode` is high after a `clk` edge exactly when `mode` was 2'b11 at that edge.
- R2: Every input is captured on a `clk` edge. After edge E, `sclk_out` equals the `sclk_base` value captured at the edge before E, ORed with the extra pulse.
- R3: Suppose that in split-transfer mode `flag` and `blank` are both captured high at edge E0, `flag` was captured low at the edge before E0, and no extra pulse is in progress. Then `sclk_out` is forced high after each of the edges E2 to E(HALF_CYC+1), which is exactly HALF_CYC cycles.
- R4: An extra pulse keeps the generator busy for 2*HALF_CYC cycles, counted from edge E1. Flag rises captured during that window are dropped, so only one extra pulse is made.
- R5: A flag rise captured while `blank` is captured low adds no pulse to `sclk_out`.
- R6: In nibble mode, when `vclk` is captured low at edge E0 after being captured high at the edge before, the nibble choice takes the `flag` value captured at E0 (1 = upper nibble, 0 = lower nibble). The new choice is in effect from edge E1.
- R7: When `sclk_base` is captured high at edge E0 after being captured low at the edge before, `nib_data` is loaded at E1 from the `pix_bus` value captured at E0. For each byte i, `nib_data[4i+3:4i]` takes `pix_bus[8i+7:8i+4]` if the choice in force before E1 is upper, and `pix_bus[8i+3:8i]` otherwise. At all other times `nib_data` holds its value.
- R8: Outside nibble mode, every load takes the lower nibbles, and `flag` and `vclk` have no effect on `nib_data`.
- R9: In the illegal mode and in the ignore mode, `flag` never adds a pulse to `sclk_out`.
- R10: While `rst` is high, all outputs are held at 0 from the next edge, and all captured state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Mode field: bit 1 is control bit 3 and bit 0 is control bit 2 |
| flag | input | 1 | Flag shared by split transfer and nibble pick |
| vclk | input | 1 | Video clock level, sampled |
| blank | input | 1 | Blanking active, high |
| sclk_base | input | 1 | Base shift clock level, sampled |
| pix_bus | input | 8*BYTES | Pixel data bus, one byte per lane |
| sclk_out | output | 1 | Shift clock with the extra pulse added |
| nib_data | output | 4*BYTES | Latched nibble of each byte |
| illegal_mode | output | 1 | The mode field holds the illegal encoding |

## Verification
The assertions take it for granted that `vclk` and `sclk_base` change far more slowly than `clk`, so that each of their edges appears in the captured values as one clean change. They also assume that `mode` is held steady while a pulse is in progress, because a changed mode cannot cut short a pulse that has already started. The stimulus drives every input on the falling edge of `clk`. It holds each level of `vclk` and `sclk_base` for at least one full `clk` cycle, and it changes `mode` only at the start of a phase, or every 64 cycles in the random phase. The random phase still lets a mode change fall during a pulse, so that the requirement that a started pulse runs to its end is exercised.

// File: rtl/pbfc_pkg.sv
package pbfc_pkg;

  typedef enum logic [1:0] {
    MODE_IGNORE = 2'b00,
    MODE_SPLIT  = 2'b01,
    MODE_NIBBLE = 2'b10,
    MODE_BAD    = 2'b11
  } flag_mode_e;

endpackage

// File: rtl/pbfc_capture.sv
module pbfc_capture
  import pbfc_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             flag,
  input  logic             vclk,
  input  logic             blank,
  input  logic             sclk_base,
  input  logic [PIX_W-1:0] pix_bus,
  output flag_mode_e       mode_q,
  output logic             flag_q,
  output logic             blank_q,
  output logic             sclk_q,
  output logic [PIX_W-1:0] pix_q,
  output logic             flag_rise,
  output logic             vclk_fall,
  output logic             sclk_rise
);

  logic vclk_q;
  logic flag_p, vclk_p, sclk_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_IGNORE;
      flag_q  <= 1'b0;
      vclk_q  <= 1'b0;
      blank_q <= 1'b0;
      sclk_q  <= 1'b0;
      pix_q   <= '0;
      flag_p  <= 1'b0;
      vclk_p  <= 1'b0;
      sclk_p  <= 1'b0;
    end else begin
      mode_q  <= flag_mode_e'(mode);
      flag_q  <= flag;
      vclk_q  <= vclk;
      blank_q <= blank;
      sclk_q  <= sclk_base;
      pix_q   <= pix_bus;
      flag_p  <= flag_q;
      vclk_p  <= vclk_q;
      sclk_p  <= sclk_q;
    end
  end

  assign flag_rise = flag_q & ~flag_p;
  assign vclk_fall = ~vclk_q & vclk_p;
  assign sclk_rise = sclk_q & ~sclk_p;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    flag_rise |=> !flag_rise); // R3

endmodule

// File: rtl/pbfc_stretch.sv
module pbfc_stretch #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic split_en,
  input  logic blank_q,
  input  logic flag_rise,
  input  logic sclk_q,
  output logic sclk_out
);

  localparam int CW = $clog2(2 * HALF_CYC + 1);
  localparam logic [CW-1:0] FULL_V = CW'(2 * HALF_CYC);
  localparam logic [CW-1:0] HALF_V = CW'(HALF_CYC);

  logic [CW-1:0] cnt_q;
  logic          start;

  assign start = (cnt_q == '0) & split_en & blank_q & flag_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sclk_out <= 1'b0;
    end else begin
      sclk_out <= sclk_q | (cnt_q > HALF_V);
      if (start)
        cnt_q <= FULL_V;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && split_en && blank_q && flag_rise) |=> (cnt_q == FULL_V)); // R3
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > CW'(1)) |=> ((cnt_q + CW'(1)) == $past(cnt_q))); // R4
  AST_NO_START_UNBLANKED: assert property (@(posedge clk) disable iff (rst)
    (!blank_q && (cnt_q == '0)) |=> (cnt_q == '0)); // R5
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
    (!split_en && (cnt_q == '0)) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pbfc_nibble.sv
module pbfc_nibble #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nib_en,
  input  logic               flag_q,
  input  logic               vclk_fall,
  input  logic               sclk_rise,
  input  logic [8*BYTES-1:0] pix_q,
  output logic [4*BYTES-1:0] nib_data
);

  localparam int NW = 4 * BYTES;

  logic          sel_q;
  logic          use_hi;
  logic [NW-1:0] pick;

  assign use_hi = nib_en & sel_q;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign pick[4*i +: 4] = use_hi ? pix_q[8*i+4 +: 4] : pix_q[8*i +: 4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= 1'b0;
      nib_data <= '0;
    end else begin
      if (!nib_en)
        sel_q <= 1'b0;
      else if (vclk_fall)
        sel_q <= flag_q;
      if (sclk_rise)
        nib_data <= pick;
    end
  end

  AST_SEL_TRACKS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (nib_en && vclk_fall) |=> (sel_q == $past(flag_q))); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(nib_data)); // R7
  AST_LOW_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (!nib_en && sclk_rise) |=> (nib_data[3:0] == $past(pix_q[3:0]))); // R8

endmodule

// File: rtl/pixbus_flag_ctrl.sv
module pixbus_flag_ctrl
  import pbfc_pkg::*;
#(
  parameter int BYTES    = 4,
  parameter int HALF_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               flag,
  input  logic               vclk,
  input  logic               blank,
  input  logic               sclk_base,
  input  logic [8*BYTES-1:0] pix_bus,
  output logic               sclk_out,
  output logic [4*BYTES-1:0] nib_data,
  output logic               illegal_mode
);

  localparam int PIX_W = 8 * BYTES;

  flag_mode_e       mode_q;
  logic             flag_q, blank_q, sclk_q;
  logic [PIX_W-1:0] pix_q;
  logic             flag_rise, vclk_fall, sclk_rise;
  logic             split_en, nib_en;

  pbfc_capture #(.PIX_W(PIX_W)) u_cap (
    .clk(clk), .rst(rst), .mode(mode), .flag(flag), .vclk(vclk),
    .blank(blank), .sclk_base(sclk_base), .pix_bus(pix_bus),
    .mode_q(mode_q), .flag_q(flag_q), .blank_q(blank_q), .sclk_q(sclk_q),
    .pix_q(pix_q), .flag_rise(flag_rise), .vclk_fall(vclk_fall),
    .sclk_rise(sclk_rise)
  );

  assign split_en = (mode_q == MODE_SPLIT);
  assign nib_en   = (mode_q == MODE_NIBBLE);

  pbfc_stretch #(.HALF_CYC(HALF_CYC)) u_str (
    .clk(clk), .rst(rst), .split_en(split_en), .blank_q(blank_q),
    .flag_rise(flag_rise), .sclk_q(sclk_q), .sclk_out(sclk_out)
  );

  pbfc_nibble #(.BYTES(BYTES)) u_nib (
    .clk(clk), .rst(rst), .nib_en(nib_en), .flag_q(flag_q),
    .vclk_fall(vclk_fall), .sclk_rise(sclk_rise), .pix_q(pix_q),
    .nib_data(nib_data)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_mode <= 1'b0;
    else     illegal_mode <= (mode == 2'b11);
  end

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
    illegal_mode |-> ($past(mode) == 2'b11)); // R1
  AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) != 2'b11) |-> !illegal_mode); // R1
  AST_RESET_OUT: assert property (@(posedge clk)
    $past(rst) |-> (!sclk_out && !illegal_mode && (nib_data == '0))); // R10

endmodule

// File: tb/pixbus_flag_ctrl_test.sv
module pixbus_flag_ctrl_test;

  localparam int BYTES = 4;
  localparam int H     = 2;
  localparam int PW    = 8 * BYTES;
  localparam int NW    = 4 * BYTES;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b00;
  logic          flag = 1'b0, vclk = 1'b0, blank = 1'b0, sclk_base = 1'b0;
  logic [PW-1:0] pix_bus = '0;
  logic          sclk_out, illegal_mode;
  logic [NW-1:0] nib_data;

  int checks = 0;
  int errors = 0;
  string phase = "R10 reset";

  pixbus_flag_ctrl #(.BYTES(BYTES), .HALF_CYC(H)) uut (
    .clk(clk), .rst(rst), .mode(mode), .flag(flag), .vclk(vclk),
    .blank(blank), .sclk_base(sclk_base), .pix_bus(pix_bus),
    .sclk_out(sclk_out), .nib_data(nib_data), .illegal_mode(illegal_mode)
  );

  always #2 clk = ~clk;

  // behavioural reference: captured inputs and previous captures
  bit [1:0]      c_mode;
  bit            c_flag, c_vclk, c_blank, c_sclk, p_flag, p_vclk, p_sclk;
  bit [PW-1:0]   c_pix;
  int            busy;
  bit            sel;
  bit            e_sclk, e_ill;
  bit [NW-1:0]   e_nib;
  bit            seen_edge = 1'b0;

  always @(posedge clk) begin
    seen_edge = 1'b1;
    if (rst) begin
      c_mode = 0; c_flag = 0; c_vclk = 0; c_blank = 0; c_sclk = 0; c_pix = 0;
      p_flag = 0; p_vclk = 0; p_sclk = 0; busy = 0; sel = 0;
      e_sclk = 0; e_ill = 0; e_nib = 0;
    end else begin
      e_sclk = c_sclk || (busy > H);
      if (busy == 0) begin
        if (c_mode == 2'b01 && c_blank && c_flag && !p_flag) busy = 2 * H;
      end else begin
        busy = busy - 1;
      end
      if (c_sclk && !p_sclk)
        for (int i = 0; i < BYTES; i++)
          e_nib[4*i +: 4] = (c_mode == 2'b10 && sel) ? c_pix[8*i+4 +: 4] : c_pix[8*i +: 4];
      if (c_mode != 2'b10) sel = 0;
      else if (!c_vclk && p_vclk) sel = c_flag;
      e_ill = (mode == 2'b11);
      p_flag = c_flag; p_vclk = c_vclk; p_sclk = c_sclk;
      c_mode = mode; c_flag = flag; c_vclk = vclk; c_blank = blank;
      c_sclk = sclk_base; c_pix = pix_bus;
    end
  end

  always @(negedge clk) begin
    if (seen_edge) begin
      checks++;
      if (sclk_out !== e_sclk || illegal_mode !== e_ill || nib_data !== e_nib) begin
        errors++;
        $display("FAIL %s: sclk_out=%0b/%0b illegal=%0b/%0b nib=%h/%h (actual/expected)",
                 phase, sclk_out, e_sclk, illegal_mode, e_ill, nib_data, e_nib);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic count_high(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (sclk_out) cnt++;
    end
  endtask

  function automatic logic [NW-1:0] nibs(input logic [PW-1:0] p, input bit hi);
    logic [NW-1:0] r;
    for (int i = 0; i < BYTES; i++)
      r[4*i +: 4] = hi ? p[8*i+4 +: 4] : p[8*i +: 4];
    return r;
  endfunction

  task automatic nib_load(input bit f, input logic [PW-1:0] p, input bit do_vclk);
    flag = f;
    if (do_vclk) begin vclk = 1'b1; step(2); vclk = 1'b0; end
    step(3);
    pix_bus = p; sclk_base = 1'b1;
    step(4);
    sclk_base = 1'b0;
    step(3);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    step(4);
    check("R10 reset sclk_out", int'(sclk_out), 0);
    check("R10 reset nib_data", int'(nib_data), 0);
    check("R10 reset illegal_mode", int'(illegal_mode), 0);
    rst = 1'b0;
    step(2);

    // R2: base shift clock passes through in ignore mode
    phase = "R2 passthrough";
    for (int k = 0; k < 40; k++) begin
      sclk_base = k[1]; pix_bus = $urandom; flag = $urandom; vclk = k[2];
      step(1);
    end
    sclk_base = 1'b0; flag = 1'b0; step(4);

    // R3: single extra pulse
    phase = "R3 extra pulse";
    mode = 2'b01; blank = 1'b1; step(4);
    flag = 1'b1;
    count_high(10, n);
    check("R3 extra pulse length", n, H);
    flag = 1'b0; step(6);

    // R4: second rise inside busy window dropped
    phase = "R4 no retrigger";
    flag = 1'b1; step(1); flag = 1'b0; step(1); flag = 1'b1;
    count_high(12, n);
    check("R4 one pulse only", n, H);
    flag = 1'b0; step(4);
    flag = 1'b1;
    count_high(10, n);
    check("R4 later rise accepted", n, H);
    flag = 1'b0; step(4);

    // R5: rise outside blanking
    phase = "R5 unblanked";
    blank = 1'b0; step(3);
    flag = 1'b1;
    count_high(10, n);
    check("R5 no pulse unblanked", n, 0);
    flag = 1'b0; step(3);

    // R6 / R7: nibble pick
    phase = "R6 R7 nibble";
    mode = 2'b10; blank = 1'b1; step(3);
    flag = 1'b1; count_high(8, n);
    check("R6 no pulse in nibble mode", n, 0);
    nib_load(1'b1, 32'hA5C3_7E19, 1'b1);
    check("R7 upper nibbles", int'(nib_data), int'(nibs(32'hA5C3_7E19, 1'b1)));
    nib_load(1'b1, 32'h1234_5678, 1'b0);
    check("R6 choice held", int'(nib_data), int'(nibs(32'h1234_5678, 1'b1)));
    nib_load(1'b0, 32'hF0E1_D2C3, 1'b1);
    check("R7 lower nibbles", int'(nib_data), int'(nibs(32'hF0E1_D2C3, 1'b0)));
    flag = 1'b1; vclk = 1'b1; step(2); vclk = 1'b0; step(2);
    check("R7 hold without load", int'(nib_data), int'(nibs(32'hF0E1_D2C3, 1'b0)));

    // R8: ignore mode takes lower nibbles
    phase = "R8 ignore mode";
    mode = 2'b00; step(3);
    nib_load(1'b1, 32'h9ABC_DEF0, 1'b1);
    check("R8 lower nibble outside nibble mode", int'(nib_data), int'(nibs(32'h9ABC_DEF0, 1'b0)));
    flag = 1'b0; step(2);
    flag = 1'b1; count_high(10, n);
    check("R9 no pulse in ignore mode", n, 0);
    flag = 1'b0;

    // R1 / R9: illegal mode
    phase = "R1 R9 illegal";
    mode = 2'b11; step(2);
    check("R1 illegal flag", int'(illegal_mode), 1);
    flag = 1'b1; count_high(10, n);
    check("R9 no pulse in illegal mode", n, 0);
    nib_load(1'b1, 32'h4B6D_8F21, 1'b1);
    check("R9 lower nibble in illegal mode", int'(nib_data), int'(nibs(32'h4B6D_8F21, 1'b0)));
    mode = 2'b01; step(2);
    check("R1 illegal clears", int'(illegal_mode), 0);

    // random mix against the reference
    phase = "R2 R3 R6 random";
    for (int k = 0; k < 3000; k++) begin
      if (k % 64 == 0) mode = 2'($urandom);
      flag = $urandom; blank = ($urandom % 4) != 0;
      vclk = $urandom; sclk_base = $urandom; pix_bus = $urandom;
      step(1);
    end

    phase = "R10 reset again";
    rst = 1'b1; step(3);
    check("R10 reset clears data", int'(nib_data), 0);
    rst = 1'b0; step(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule